// File: doc/BRIEF.md
# Pipelined one-dimensional Haar transform

This block takes a vector of N signed samples, all presented in the same cycle, and returns its Haar decomposition a fixed number of cycles later. At each level, neighbouring samples are paired. Each pair produces a truncated mean, which is written to the lower half of the active region, and a full-precision difference, which is written to the upper half. Each further level works only on the means that the level before it produced. Coefficients already placed above the active region move forward unchanged.

The block is fully pipelined. It can accept a new vector in every cycle while `free` is high. Every accepted vector comes out exactly N/2+4 cycles later, whatever the level count, so downstream logic can be scheduled against a constant delay. Every output element is W+1 bits wide and signed. A mean always fits in W bits and is sign-extended into that field.

Top module: `haar1d_pipe`

## Requirements
- R1: For pair index i in 0..N/2-1 of the first level, output element i (bits i*(W+1) upward) equals floor((x[2i]+x[2i+1])/2), where input element k sits at bits k*W upward and is read as two's complement.
- R2: Output element N/2+i equals x[2i]-x[2i+1] as a signed W+1-bit value, not halved, and it never overflows (for example 127-(-128)=255 when W=8).
- R3: With LEVELS=L, level l (starting at 1) transforms only elements 0..(N>>(l-1))-1 of the previous level's result, in the same mean/difference arrangement. Elements above that range keep their values from the earlier level.
- R4: A vector accepted in cycle t (in_valid high and free high at the rising edge that ends t) drives out_valid high together with its coefficients in cycle t+N/2+4. At all other times out_valid is low.
- R5: Vectors accepted in consecutive cycles come out in consecutive cycles and in the same order.
- R6: While rst_n is low, free is low. It rises at the first rising edge that sees rst_n high and then stays high. A vector offered while free is low is discarded and produces no output.
- R7: Means round toward minus infinity for negative sums as well (for example, inputs -3 and 0 give -2).
- R8: During reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers in_data in this cycle |
| in_data | input | N*W | N signed samples; element k at bits k*W upward |
| free | output | 1 | Block can take a vector in this cycle |
| out_valid | output | 1 | out_data holds a finished coefficient vector |
| out_data | output | N*(W+1) | N signed coefficients; element k at bits k*(W+1) upward |

## Verification
The assertions assume the source never sees `free` fall once reset has ended. They also assume that a sample is never wider than W bits, which makes the first stage's mean and difference invertible. The range check on the DC term relies on the same assumption. The stimulus draws every sample from the full signed W-bit range. It offers vectors during reset only to show that they are discarded, and afterwards it leaves `rst_n` high. This means the reconstruction check always compares the first-level outputs with the pair that was actually captured.

// File: rtl/haar1d_pipe.sv
module haar1d_pipe #(
  parameter int N      = 8,
  parameter int W      = 8,
  parameter int LEVELS = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [N*W-1:0]     in_data,
  output logic               free,
  output logic               out_valid,
  output logic [N*(W+1)-1:0] out_data
);
  localparam int EW  = W + 1;
  localparam int LAT = N / 2 + 4;
  localparam int PAD = LAT - 1 - LEVELS;
  localparam int CW  = $clog2(LAT + 1) + 1;

  logic signed [EW-1:0] st [0:LEVELS][0:N-1];
  logic [LAT-1:0]       vpipe;
  logic                 free_q;
  logic [N*EW-1:0]      last_flat;
  wire                  take = in_valid & free_q;

  assign free      = free_q;
  assign out_valid = vpipe[LAT-1];

  function automatic logic signed [EW-1:0] avg2(input logic signed [EW-1:0] a, input logic signed [EW-1:0] b);
    logic signed [EW:0] s;
    s = a + b;
    return s[EW:1];
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      free_q <= 1'b0;
      vpipe  <= '0;
    end else begin
      free_q <= 1'b1;
      vpipe  <= {vpipe[LAT-2:0], take};
    end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++)
      if (take) st[0][i] <= {in_data[i*W+W-1], in_data[i*W +: W]};
    for (int l = 1; l <= LEVELS; l++) begin
      for (int i = 0; i < N / 2; i++)
        if (i < ((N >> (l - 1)) / 2)) begin
          st[l][i] <= avg2(st[l-1][2*i], st[l-1][2*i+1]);
          st[l][((N >> (l - 1)) / 2) + i] <= st[l-1][2*i] - st[l-1][2*i+1];
        end
      for (int i = 0; i < N; i++)
        if (i >= (N >> (l - 1))) st[l][i] <= st[l-1][i];
    end
  end

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_pack
      assign last_flat[k*EW +: EW] = st[LEVELS][k];
    end
    if (PAD > 0) begin : g_delay
      logic [N*EW-1:0] dly [0:PAD-1];
      always_ff @(posedge clk) begin
        dly[0] <= last_flat;
        for (int j = 1; j < PAD; j++) dly[j] <= dly[j-1];
      end
      assign out_data = dly[PAD-1];
    end else begin : g_nodelay
      assign out_data = last_flat;
    end
  endgenerate

  logic [CW-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + {{(CW-1){1'b0}}, take} - {{(CW-1){1'b0}}, out_valid};

  logic signed [EW+1:0] mean_w, diff_w, rsum, rec_a, rec_b;
  assign mean_w = st[1][0];
  assign diff_w = st[1][N/2];
  assign rsum   = diff_w + $signed({{(EW+1){1'b0}}, diff_w[0]});
  assign rec_a  = mean_w + (rsum >>> 1);
  assign rec_b  = rec_a - diff_w;

  p_free_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n) free |=> free);
  p_invertible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vpipe[1] |-> rec_a == $past(st[0][0]));
  p_pair_diff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vpipe[1] |-> rec_b == $past(st[0][1]));
  p_out_owed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != '0);
  p_inflight_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));
  p_dc_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[EW-1] == out_data[EW-2]);
endmodule

// File: tb/tb_haar1d_pipe.sv
`timescale 1ns/100ps
module tb_haar1d_pipe;
  localparam int N = 8, W = 8, EW = 9, LAT = N / 2 + 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0;
  logic [N*W-1:0] in_data = '0;
  logic free1, free3, ov1, ov3;
  logic [N*EW-1:0] od1, od3;

  haar1d_pipe #(.N(N), .W(W), .LEVELS(1)) dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .free(free1), .out_valid(ov1), .out_data(od1));
  haar1d_pipe #(.N(N), .W(W), .LEVELS(3)) dut_full (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .free(free3), .out_valid(ov3), .out_data(od3));

  int cyc = 0;
  logic rst_seen = 1'b0;
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    rst_seen <= rst_n;
  end

  logic [N*EW-1:0] exp1 [int];
  logic [N*EW-1:0] exp3 [int];
  int n_chk = 0, n_fail = 0;

  function automatic logic [N*EW-1:0] ref_haar(input logic [N*W-1:0] v, input int levels);
    int y [N];
    int t [N];
    int len, s;
    logic [N*EW-1:0] r;
    for (int k = 0; k < N; k++) y[k] = int'($signed(v[k*W +: W]));
    len = N;
    for (int l = 0; l < levels; l++) begin
      for (int k = 0; k < N; k++) t[k] = y[k];
      for (int i = 0; i < len / 2; i++) begin
        s = y[2*i] + y[2*i+1];
        t[i] = (s - (s & 1)) / 2;
        t[len/2 + i] = y[2*i] - y[2*i+1];
      end
      for (int k = 0; k < N; k++) y[k] = t[k];
      len = len / 2;
    end
    for (int k = 0; k < N; k++) r[k*EW +: EW] = y[k][EW-1:0];
    return r;
  endfunction

  task automatic cmp_vec(input string who, input logic [N*EW-1:0] act, input logic [N*EW-1:0] exp, input bit full);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      for (int k = 0; k < N; k++)
        if (act[k*EW +: EW] !== exp[k*EW +: EW]) begin
          $display("FAIL %s %s element %0d at cycle %0d: actual %0d expected %0d", who,
                   full ? "R3" : (k < N/2 ? "R1" : "R2"), k, cyc,
                   $signed(act[k*EW +: EW]), $signed(exp[k*EW +: EW]));
          break;
        end
    end
  endtask

  always @(negedge clk) begin
    n_chk++;
    if (free1 !== rst_seen || free3 !== rst_seen) begin
      n_fail++;
      $display("FAIL R6 free at cycle %0d: actual %b/%b expected %b", cyc, free1, free3, rst_seen);
    end
    n_chk++;
    if (ov1 !== exp1.exists(cyc) || ov3 !== exp3.exists(cyc)) begin
      n_fail++;
      $display("FAIL R4 out_valid at cycle %0d: actual %b/%b expected %b/%b", cyc, ov1, ov3,
               exp1.exists(cyc), exp3.exists(cyc));
    end
    if (exp1.exists(cyc)) begin
      if (ov1) cmp_vec("dut", od1, exp1[cyc], 1'b0);
      exp1.delete(cyc);
    end
    if (exp3.exists(cyc)) begin
      if (ov3) cmp_vec("dut_full", od3, exp3[cyc], 1'b1);
      exp3.delete(cyc);
    end
  end

  task automatic offer(input logic [N*W-1:0] v, input logic vld);
    @(negedge clk);
    #1;
    in_valid = vld;
    in_data  = v;
    if (vld && rst_seen) begin
      exp1[cyc + LAT] = ref_haar(v, 1);
      exp3[cyc + LAT] = ref_haar(v, 3);
    end
  endtask

  function automatic logic [N*W-1:0] mk(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [N*W-1:0] v;
    v = {a7[W-1:0], a6[W-1:0], a5[W-1:0], a4[W-1:0], a3[W-1:0], a2[W-1:0], a1[W-1:0], a0[W-1:0]};
    return v;
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    n_chk++;
    if (ov1 !== 1'b0 || ov3 !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset out_valid: actual %b/%b expected 0", ov1, ov3);
    end
    // R6: vectors offered while reset holds free low are discarded
    for (int r = 0; r < 3; r++) offer(mk(5, 6, 7, 8, 9, 10, 11, 12), 1'b1);
    @(negedge clk); #1 rst_n = 1'b1; in_valid = 1'b1;
    offer(mk(1, 2, 3, 4, 5, 6, 7, 8), 1'b0);
    offer(mk(0, 0, 0, 0, 0, 0, 0, 0), 1'b1);
    offer(mk(1, 2, 3, 4, 5, 6, 7, 8), 1'b1);
    offer('0, 1'b0);
    offer(mk(-3, 0, -1, -2, -5, 4, -128, -127), 1'b1);   // R7 negative means
    offer('0, 1'b0);
    offer('0, 1'b0);
    offer(mk(127, -128, -128, 127, 127, 127, -128, -128), 1'b1); // R2 extremes
    offer(mk(127, 127, 127, 127, 127, 127, 127, 127), 1'b1);
    offer(mk(-128, -128, -128, -128, -128, -128, -128, -128), 1'b1);
    for (int r = 0; r < 40; r++) offer($urandom, 1'b1);   // R5 back-to-back
    for (int r = 0; r < 30; r++) offer($urandom, r[0]);
    offer('0, 1'b0);
    repeat (LAT + 4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule